// File: doc/BRIEF.md
# Escape-Sequence Guard-Time Detector

This block watches the byte stream coming out of a serial receiver and recognises an escape sequence: a run of one configured character, repeated a configured number of times, with a quiet period before the run, short gaps inside it and another quiet period after it. Matching the byte values is not enough. The block accepts a sequence only when the line timing around and inside the run also meets the limits. This lets a modem-style command escape be told apart from the same characters turning up inside ordinary data.

The deframer gives the block a one-cycle strobe with each received byte. The baud generator gives it a one-cycle tick once per bit time, and every duration is counted in these ticks. One counter measures the time since the last received byte. A small state machine walks through three phases: waiting for the leading quiet time, collecting the run, and waiting for the trailing quiet time. A successful detection produces a single-cycle pulse, and that pulse sets a sticky flag which stays set until it is cleared. The configuration inputs are held steady by the surrounding register logic. The usual settings for that logic are in the package: character 0x2B, count 3, leading and trailing quiet time 2305 ticks, and gap limit 11 ticks.

Top module: `esc_seq_detect`

## Requirements
- R1: After reset, det_pulse and det_flag are 0 and the idle time starts from zero, so the full leading quiet time must pass after reset before an escape character is counted.
- R2: Idle time is the number of bit_tick cycles seen since the last byte strobe; a strobe restarts it at zero. The first escape character of a run is counted only if the idle time at its arrival is at least cfg_pre_idle.
- R3: Each further escape character of a run is counted if its idle time is at most cfg_max_gap. If the idle time goes beyond cfg_max_gap the run is dropped, and the late character is not counted.
- R4: A byte whose 8 bits differ from cfg_esc_char drops any partial or complete run, and the block goes back to waiting for the leading quiet time.
- R5: Once the required number of escape characters has been counted, det_pulse goes high for exactly one cycle when the idle time reaches cfg_post_idle with no byte in between. An idle time of exactly cfg_post_idle is enough.
- R6: Any byte that arrives before the trailing quiet time has elapsed cancels the detection. This includes one more escape character beyond the required count.
- R7: A cfg_esc_count of 0 behaves as a count of 1.
- R8: det_flag goes to 1 after a det_pulse and stays at 1 until flag_clr is asserted, which returns it to 0.
- R9: The escape character is taken from cfg_esc_char. When this setting changes, a run of the old character is no longer recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| byte_vld | input | 1 | One-cycle strobe for a received byte |
| byte_data | input | 8 | Received byte value |
| cfg_esc_char | input | 8 | Escape character to match |
| cfg_esc_count | input | 8 | Number of escape characters in a run |
| cfg_pre_idle | input | 16 | Leading quiet time, in ticks |
| cfg_post_idle | input | 16 | Trailing quiet time, in ticks |
| cfg_max_gap | input | 16 | Largest idle time allowed between run characters, in ticks |
| flag_clr | input | 1 | Clears the sticky flag |
| det_pulse | output | 1 | One-cycle detection pulse |
| det_flag | output | 1 | Sticky detection flag |

## Verification
If the idle counter fails to restart on a byte, a sequence whose leading quiet time is too short gets accepted. That shows up as a det_pulse within a few ticks of the last character, where the bench expects none. If the phase machine is stuck in the collecting or trailing phase, the result is either a pulse that never comes after a clean sequence or a pulse after a cancelled one. The bench sees this within one trailing window, about a dozen ticks. The boundary scenarios sit exactly on the limits (leading time equal to the limit, gap equal to the limit, a byte one tick before the trailing limit), so an off-by-one in any comparison changes the pulse count of that scenario.

// File: rtl/esc_det_pkg.sv
package esc_det_pkg;

    localparam int unsigned ESC_CHAR_W = 8;
    localparam int unsigned ESC_CNT_W  = 8;
    localparam int unsigned ESC_TIME_W = 16;

    // Power-on settings expected from the surrounding register block
    localparam logic [7:0]  ESC_CHAR_RST  = 8'h2B;
    localparam logic [7:0]  ESC_COUNT_RST = 8'd3;
    localparam logic [15:0] ESC_PRE_RST   = 16'd2305;
    localparam logic [15:0] ESC_POST_RST  = 16'd2305;
    localparam logic [15:0] ESC_GAP_RST   = 16'd11;

    typedef enum logic [1:0] {
        ST_WAIT_PRE  = 2'd0,
        ST_RUN       = 2'd1,
        ST_WAIT_POST = 2'd2
    } esc_state_e;

endpackage

// File: rtl/esc_idle_timer.sv
module esc_idle_timer #(
    parameter int unsigned TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              byte_vld,
    output logic [TIME_W-1:0] idle_cnt
);

    localparam logic [TIME_W-1:0] SAT = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
        end else if (byte_vld) begin
            idle_cnt <= '0;
        end else if (bit_tick && idle_cnt != SAT) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // R2: a byte restarts the idle measurement
    assert_idle_restart_R2: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> idle_cnt == '0);

    // R2: idle time only moves on a tick
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!byte_vld && !bit_tick) |=> $stable(idle_cnt));

endmodule

// File: rtl/esc_seq_fsm.sv
module esc_seq_fsm
    import esc_det_pkg::*;
#(
    parameter int unsigned CHAR_W = 8,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [CHAR_W-1:0] byte_data,
    input  logic [TIME_W-1:0] idle_cnt,
    input  logic [CHAR_W-1:0] cfg_esc_char,
    input  logic [CNT_W-1:0]  cfg_esc_count,
    input  logic [TIME_W-1:0] cfg_pre_idle,
    input  logic [TIME_W-1:0] cfg_post_idle,
    input  logic [TIME_W-1:0] cfg_max_gap,
    output logic              det_pulse
);

    esc_state_e        state;
    logic [CNT_W-1:0]  run_cnt;
    logic [CNT_W-1:0]  target;
    logic [CNT_W:0]    run_next;
    logic              is_esc;
    logic              in_gap;

    always_comb begin
        target   = (cfg_esc_count == '0) ? CNT_W'(1) : cfg_esc_count;
        run_next = {1'b0, run_cnt} + 1'b1;
        is_esc   = (byte_data == cfg_esc_char);
        in_gap   = (idle_cnt <= cfg_max_gap);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_WAIT_PRE;
            run_cnt   <= '0;
            det_pulse <= 1'b0;
        end else begin
            det_pulse <= 1'b0;
            unique case (state)
                ST_WAIT_PRE: begin
                    if (byte_vld && is_esc && idle_cnt >= cfg_pre_idle) begin
                        run_cnt <= CNT_W'(1);
                        state   <= (target == CNT_W'(1)) ? ST_WAIT_POST : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (byte_vld) begin
                        if (is_esc && in_gap) begin
                            run_cnt <= run_next[CNT_W-1:0];
                            if (run_next >= {1'b0, target}) begin
                                state <= ST_WAIT_POST;
                            end
                        end else begin
                            state <= ST_WAIT_PRE;
                        end
                    end else if (!in_gap) begin
                        state <= ST_WAIT_PRE;
                    end
                end
                ST_WAIT_POST: begin
                    if (byte_vld) begin
                        state <= ST_WAIT_PRE;
                    end else if (idle_cnt >= cfg_post_idle) begin
                        det_pulse <= 1'b1;
                        state     <= ST_WAIT_PRE;
                    end
                end
                default: state <= ST_WAIT_PRE;
            endcase
        end
    end

    // R4: a non-matching byte always returns to the leading-quiet phase
    assert_mismatch_restart_R4: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && byte_data != cfg_esc_char) |=> state == ST_WAIT_PRE);

    // R3: a run whose gap runs out is dropped
    assert_gap_abandon_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !byte_vld && idle_cnt > cfg_max_gap) |=> state == ST_WAIT_PRE);

    // R5: the detection pulse lasts one cycle
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
        det_pulse |=> !det_pulse);

    // R6: a byte in the trailing window suppresses the pulse
    assert_post_cancel_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_POST && byte_vld) |=> (!det_pulse && state == ST_WAIT_PRE));

endmodule

// File: rtl/esc_flag.sv
module esc_flag (
    input  logic clk,
    input  logic rst,
    input  logic det_pulse,
    input  logic flag_clr,
    output logic det_flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            det_flag <= 1'b0;
        end else if (det_pulse) begin
            det_flag <= 1'b1;
        end else if (flag_clr) begin
            det_flag <= 1'b0;
        end
    end

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
        det_pulse |=> det_flag);

    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (det_flag && !flag_clr) |=> det_flag);

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !det_pulse) |=> !det_flag);

endmodule

// File: rtl/esc_seq_detect.sv
module esc_seq_detect
    import esc_det_pkg::*;
#(
    parameter int unsigned CHAR_W = ESC_CHAR_W,
    parameter int unsigned CNT_W  = ESC_CNT_W,
    parameter int unsigned TIME_W = ESC_TIME_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              byte_vld,
    input  logic [CHAR_W-1:0] byte_data,
    input  logic [CHAR_W-1:0] cfg_esc_char,
    input  logic [CNT_W-1:0]  cfg_esc_count,
    input  logic [TIME_W-1:0] cfg_pre_idle,
    input  logic [TIME_W-1:0] cfg_post_idle,
    input  logic [TIME_W-1:0] cfg_max_gap,
    input  logic              flag_clr,
    output logic              det_pulse,
    output logic              det_flag
);

    logic [TIME_W-1:0] idle_cnt;

    esc_idle_timer #(.TIME_W(TIME_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (bit_tick),
        .byte_vld (byte_vld),
        .idle_cnt (idle_cnt)
    );

    esc_seq_fsm #(.CHAR_W(CHAR_W), .CNT_W(CNT_W), .TIME_W(TIME_W)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .byte_vld      (byte_vld),
        .byte_data     (byte_data),
        .idle_cnt      (idle_cnt),
        .cfg_esc_char  (cfg_esc_char),
        .cfg_esc_count (cfg_esc_count),
        .cfg_pre_idle  (cfg_pre_idle),
        .cfg_post_idle (cfg_post_idle),
        .cfg_max_gap   (cfg_max_gap),
        .det_pulse     (det_pulse)
    );

    esc_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .det_pulse (det_pulse),
        .flag_clr  (flag_clr),
        .det_flag  (det_flag)
    );

endmodule

// File: tb/test_esc_seq_detect.sv
module test_esc_seq_detect;

    localparam int PRE  = 8;
    localparam int POST = 8;
    localparam int GAP  = 4;
    localparam logic [7:0] ESC   = 8'h2B;
    localparam logic [7:0] OTHER = 8'h41;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_tick = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [7:0]  cfg_esc_char = ESC;
    logic [7:0]  cfg_esc_count = 8'd3;
    logic [15:0] cfg_pre_idle = 16'(PRE);
    logic [15:0] cfg_post_idle = 16'(POST);
    logic [15:0] cfg_max_gap = 16'(GAP);
    logic        flag_clr = 1'b0;
    logic        det_pulse;
    logic        det_flag;

    int n_chk  = 0;
    int n_fail = 0;
    int cur_id = 0;
    int exp_q[$];
    bit finished = 1'b0;

    always #5 clk = ~clk;

    esc_seq_detect i_esc_seq_detect (
        .clk           (clk),
        .rst           (rst),
        .bit_tick      (bit_tick),
        .byte_vld      (byte_vld),
        .byte_data     (byte_data),
        .cfg_esc_char  (cfg_esc_char),
        .cfg_esc_count (cfg_esc_count),
        .cfg_pre_idle  (cfg_pre_idle),
        .cfg_post_idle (cfg_post_idle),
        .cfg_max_gap   (cfg_max_gap),
        .flag_clr      (flag_clr),
        .det_pulse     (det_pulse),
        .det_flag      (det_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (scenario %0d)", req, act, exp, cur_id);
        end
    endtask

    // bit-time tick: one cycle in four
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 4;
            bit_tick = (ph == 0);
        end
    end

    // monitor: every pulse must match a queued expectation
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && det_pulse) begin
                if (exp_q.size() == 0) begin
                    chk("R5 unexpected pulse", 1, 0);
                end else begin
                    chk("R5 pulse scenario", cur_id, exp_q.pop_front());
                end
            end
        end
    end

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (bit_tick !== 1'b1) @(posedge clk);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_vld  = 1'b1;
        byte_data = b;
        @(negedge clk);
        byte_vld  = 1'b0;
    endtask

    task automatic expect_det();
        exp_q.push_back(cur_id);
    endtask

    task automatic start_scn(input int id);
        cur_id = id;
        send(OTHER);
        wait_ticks(PRE);
    endtask

    task automatic end_scn(input string req, input int exp_flag);
        wait_ticks(POST + 4);
        @(negedge clk);
        chk(req, exp_q.size(), 0);
        chk("R8 flag state", int'(det_flag), exp_flag);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        @(negedge clk);
        chk("R8 flag cleared", int'(det_flag), 0);
    endtask

    task automatic three_esc(input int g1, input int g2);
        send(cfg_esc_char);
        wait_ticks(g1);
        send(cfg_esc_char);
        wait_ticks(g2);
        send(cfg_esc_char);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: outputs low after reset
        chk("R1 pulse after reset", int'(det_pulse), 0);
        chk("R1 flag after reset", int'(det_flag), 0);

        // R1: leading quiet time counts from reset, 7 ticks is too short
        cur_id = 1;
        wait_ticks(PRE - 1);
        three_esc(2, 2);
        end_scn("R1 no detect right after reset", 0);

        // R2 R5: nominal sequence, leading time exactly at limit
        start_scn(2);
        three_esc(2, 2);
        expect_det();
        wait_ticks(20);
        chk("R8 flag sticky", int'(det_flag), 1);
        end_scn("R5 nominal detect", 1);

        // R2: leading quiet time one tick short
        cur_id = 3;
        send(OTHER);
        wait_ticks(PRE - 1);
        three_esc(2, 2);
        end_scn("R2 short pre-idle", 0);

        // R3: gap exactly at limit is accepted
        start_scn(4);
        three_esc(GAP, GAP);
        expect_det();
        end_scn("R3 gap at limit", 1);

        // R3: gap one tick over limit drops the run
        start_scn(5);
        three_esc(2, GAP + 1);
        end_scn("R3 gap exceeded", 0);

        // R4: other byte inside run
        start_scn(6);
        send(ESC);
        wait_ticks(1);
        send(OTHER);
        wait_ticks(1);
        send(ESC);
        wait_ticks(1);
        send(ESC);
        end_scn("R4 mismatch in run", 0);

        // R6: byte one tick before the trailing limit
        start_scn(7);
        three_esc(2, 2);
        wait_ticks(POST - 1);
        send(OTHER);
        end_scn("R6 byte in post window", 0);

        // R6: extra escape character beyond the count
        start_scn(8);
        three_esc(2, 2);
        wait_ticks(2);
        send(ESC);
        end_scn("R6 extra escape char", 0);

        // R5: trailing time exactly at limit gives a pulse within two cycles
        start_scn(9);
        three_esc(3, 1);
        expect_det();
        wait_ticks(POST);
        repeat (3) @(negedge clk);
        chk("R5 exact post-idle", exp_q.size(), 0);
        end_scn("R5 exact post-idle end", 1);

        // R7: count 0 behaves as 1
        cfg_esc_count = 8'd0;
        start_scn(10);
        send(ESC);
        expect_det();
        end_scn("R7 count zero", 1);
        cfg_esc_count = 8'd3;

        // R9: new escape character recognised, old one not
        cfg_esc_char = 8'h7E;
        start_scn(11);
        three_esc(2, 2);
        expect_det();
        end_scn("R9 new char", 1);

        start_scn(12);
        send(ESC);
        wait_ticks(2);
        send(ESC);
        wait_ticks(2);
        send(ESC);
        end_scn("R9 old char ignored", 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule